// File: doc/BRIEF.md
# Positional Cube Operation Unit

This unit operates on product terms over a fixed set of multiple-valued input variables. Each term is held in positional form. Every variable owns a field of one bit per value it can take, and a set bit marks a value that belongs to the literal. One command takes two such cubes, A and B, and an opcode. The unit can form their intersection or union. It can complement each literal of A within its own field. It can test whether A and B may be merged, or simply measure A.

Whatever the opcode, the unit also measures the resulting cube. It reports whether any literal is empty and how many literals are full. It computes the cube's size, which is the integer product of the literal cardinalities. The size is built one field per clock, so a command takes a fixed number of cycles. Commands enter on a valid/ready handshake. Results appear together with a one-cycle done pulse and stay put until the next done.

Top module: `cube_op_unit`

## Requirements
- R1: Variable i occupies a field of VAR_SIZES[i] bits (2 to 4), packed upward from bit 0 with variable 0 lowest. Bit j of a field set means value j is in the literal. All bits set is a full literal and no bits set is an empty literal.
- R2: Opcode 0 gives the bitwise intersection A AND B. The unused codes 5, 6 and 7 behave exactly like opcode 0.
- R3: Opcode 1 gives the bitwise union A OR B.
- R4: Opcode 2 inverts every bit of each field of A, which is a per-literal set complement. Cube B has no effect on the result.
- R5: Opcode 3 returns A OR B. The merge flag is 1 when A and B differ in at most one field, including the case where they are identical, and 0 otherwise. For every other opcode the merge flag is 0.
- R6: Opcode 4 returns A unchanged. For every opcode the size output is the product, over all fields of the result, of the number of set bits in the field.
- R7: The void flag is 1 when any field of the result is empty, and the size output is then 0.
- R8: The don't-care count equals the number of result fields whose bits are all set.
- R9: Ready is high when idle, and a command is taken on a clock edge where valid and ready are both high. Ready stays low until done, which is a one-cycle pulse appearing NUM_VARS+1 cycles after the accepting edge. Ready is high again in the done cycle.
- R10: Valid asserted while ready is low captures nothing. The running command's results are unaffected and no extra done follows.
- R11: After reset, ready is 1, done is 0, and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_op | input | 3 | Opcode: 0 AND, 1 OR, 2 complement A, 3 merge, 4 size of A |
| cmd_a | input | CUBE_W | Cube A in positional form |
| cmd_b | input | CUBE_W | Cube B in positional form |
| done | output | 1 | One-cycle pulse when results are updated |
| res_cube | output | CUBE_W | Result cube |
| res_size | output | ACC_W | Product of literal cardinalities of the result |
| res_void | output | 1 | Some result field is empty |
| res_merge_ok | output | 1 | A and B differ in at most one field (merge opcode only) |
| res_dc_cnt | output | CNT_W | Number of full fields in the result |

## Verification
The assertions assume that the source drives cmd_op, cmd_a and cmd_b with known values whenever cmd_valid is high. They also assume that bits of cmd_a and cmd_b beyond CUBE_W are absent, because the port is exactly CUBE_W wide. The containment and merge checks look at the command only on the accepting edge, so the source may change the operands freely while ready is low. The stimulus builds every cube from a per-variable nibble, masked to that field's width. It holds the operands stable on the accepting edge and drops valid on the following falling edge, except in the scenario that deliberately keeps offering a new command while the unit is busy.

// File: rtl/cube_op_pkg.sv
package cube_op_pkg;
  localparam int unsigned MAX_VARS = 8;
  localparam int unsigned SZ_BITS  = 3;
  localparam int unsigned MAX_FW   = 4;

  typedef enum logic [2:0] {
    OP_AND   = 3'd0,
    OP_OR    = 3'd1,
    OP_NOT   = 3'd2,
    OP_MERGE = 3'd3,
    OP_SIZE  = 3'd4
  } cube_op_e;

  function automatic int unsigned field_width(input logic [MAX_VARS*SZ_BITS-1:0] sizes,
                                              input int unsigned idx);
    return 32'(sizes[idx*SZ_BITS +: SZ_BITS]);
  endfunction

  // Bit position of the first bit of field idx (sum of all lower widths).
  function automatic int unsigned field_offset(input logic [MAX_VARS*SZ_BITS-1:0] sizes,
                                               input int unsigned idx);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 0; k < MAX_VARS; k++)
      if (k < idx) acc += 32'(sizes[k*SZ_BITS +: SZ_BITS]);
    return acc;
  endfunction

  // Cardinality of a literal: number of set bits.
  function automatic logic [2:0] set_card(input logic [MAX_FW-1:0] f);
    logic [2:0] n;
    n = '0;
    for (int k = 0; k < MAX_FW; k++) n = n + 3'(f[k]);
    return n;
  endfunction
endpackage

// File: rtl/cube_field_lane.sv
module cube_field_lane
  import cube_op_pkg::*;
#(
  parameter int unsigned W = 2
) (
  input  cube_op_e     op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] r,
  output logic         full,
  output logic         empty,
  output logic         differs,
  output logic [2:0]   card
);
  always_comb begin
    case (op)
      OP_OR:    r = a | b;
      OP_NOT:   r = ~a;
      OP_MERGE: r = a | b;
      OP_SIZE:  r = a;
      default:  r = a & b;
    endcase
  end

  assign full    = &r;
  assign empty   = ~|r;
  assign differs = (a != b);
  assign card    = set_card(MAX_FW'(r));
endmodule

// File: rtl/cube_size_walker.sv
module cube_size_walker #(
  parameter int unsigned NUM_VARS = 8,
  parameter int unsigned ACC_W    = 17
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [NUM_VARS*3-1:0] cards,
  output logic                  busy,
  output logic                  last_step,
  output logic                  fin,
  output logic [ACC_W-1:0]      size_q
);
  localparam int unsigned IDX_W = (NUM_VARS > 1) ? $clog2(NUM_VARS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_VARS - 1);

  logic [IDX_W-1:0] idx;
  logic [ACC_W-1:0] acc;
  logic [2:0]       cur_card;
  logic [ACC_W-1:0] product;

  assign cur_card  = cards[int'(idx)*3 +: 3];
  assign product   = ACC_W'(acc * ACC_W'(cur_card));
  assign last_step = busy && (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      acc    <= '0;
      fin    <= 1'b0;
      size_q <= '0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
        acc  <= ACC_W'(1);
      end else if (busy) begin
        acc <= product;
        if (last_step) begin
          busy   <= 1'b0;
          fin    <= 1'b1;
          size_q <= product;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // An empty literal seen during the walk zeroes the running product for good.
  assert_empty_zeroes_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && cur_card == 3'd0) |=> (acc == '0));
endmodule

// File: rtl/cube_op_unit.sv
module cube_op_unit
  import cube_op_pkg::*;
#(
  parameter int unsigned NUM_VARS = 8,
  parameter logic [MAX_VARS*SZ_BITS-1:0] VAR_SIZES =
    {3'd2, 3'd4, 3'd2, 3'd3, 3'd2, 3'd4, 3'd3, 3'd2},
  localparam int unsigned CUBE_W = field_offset(VAR_SIZES, NUM_VARS),
  localparam int unsigned ACC_W  = 2 * NUM_VARS + 1,
  localparam int unsigned CNT_W  = $clog2(NUM_VARS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [CUBE_W-1:0] cmd_a,
  input  logic [CUBE_W-1:0] cmd_b,
  output logic              done,
  output logic [CUBE_W-1:0] res_cube,
  output logic [ACC_W-1:0]  res_size,
  output logic              res_void,
  output logic              res_merge_ok,
  output logic [CNT_W-1:0]  res_dc_cnt
);
  cube_op_e              op_e;
  logic [CUBE_W-1:0]     lane_res;
  logic [NUM_VARS-1:0]   full_v, empty_v, diff_v;
  logic [NUM_VARS*3-1:0] card_v;
  logic                  accept;
  logic                  merge_next;
  logic                  wk_busy, last_step;

  logic [CUBE_W-1:0]     work_cube;
  logic                  work_void, work_merge;
  logic [CNT_W-1:0]      work_dc;
  logic [NUM_VARS*3-1:0] card_q;

  assign op_e       = cube_op_e'(cmd_op);
  assign cmd_ready  = !wk_busy;
  assign accept     = cmd_valid && cmd_ready;
  assign merge_next = (op_e == OP_MERGE) && ($countones(diff_v) <= 1);

  for (genvar gi = 0; gi < NUM_VARS; gi++) begin : g_lane
    localparam int unsigned OFF = field_offset(VAR_SIZES, gi);
    localparam int unsigned W   = field_width(VAR_SIZES, gi);
    cube_field_lane #(.W(W)) u_lane (
      .op      (op_e),
      .a       (cmd_a[OFF +: W]),
      .b       (cmd_b[OFF +: W]),
      .r       (lane_res[OFF +: W]),
      .full    (full_v[gi]),
      .empty   (empty_v[gi]),
      .differs (diff_v[gi]),
      .card    (card_v[gi*3 +: 3])
    );
  end

  cube_size_walker #(.NUM_VARS(NUM_VARS), .ACC_W(ACC_W)) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .cards     (card_q),
    .busy      (wk_busy),
    .last_step (last_step),
    .fin       (done),
    .size_q    (res_size)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_cube    <= '0;
      work_void    <= 1'b0;
      work_merge   <= 1'b0;
      work_dc      <= '0;
      card_q       <= '0;
      res_cube     <= '0;
      res_void     <= 1'b0;
      res_merge_ok <= 1'b0;
      res_dc_cnt   <= '0;
    end else begin
      if (accept) begin
        work_cube  <= lane_res;
        work_void  <= |empty_v;
        work_merge <= merge_next;
        work_dc    <= CNT_W'($countones(full_v));
        card_q     <= card_v;
      end
      if (last_step) begin
        res_cube     <= work_cube;
        res_void     <= work_void;
        res_merge_ok <= work_merge;
        res_dc_cnt   <= work_dc;
      end
    end
  end

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_ready);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_hold_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && !last_step) |=> $stable(res_cube));
  assert_and_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_e == OP_AND) |-> ((lane_res & ~cmd_a) == '0 && (lane_res & ~cmd_b) == '0));
  assert_or_superset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_e == OP_OR) |-> ((lane_res & cmd_a) == cmd_a && (lane_res & cmd_b) == cmd_b));
  assert_merge_identical_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_e == OP_MERGE && cmd_a == cmd_b) |-> (lane_res == cmd_a && merge_next));
  assert_void_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_void) |-> (res_size == '0));
endmodule

// File: tb/test_cube_op_unit.sv
`timescale 1ns/1ps
module test_cube_op_unit;
  localparam int NV = 8;
  localparam logic [23:0] SZ = {3'd2, 3'd4, 3'd2, 3'd3, 3'd2, 3'd4, 3'd3, 3'd2};
  localparam int CW = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic [CW-1:0] cmd_a = '0, cmd_b = '0;
  logic          done;
  logic [CW-1:0] res_cube;
  logic [16:0]   res_size;
  logic          res_void, res_merge_ok;
  logic [3:0]    res_dc_cnt;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cube_op_unit i_cube_op_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b), .done(done),
    .res_cube(res_cube), .res_size(res_size), .res_void(res_void),
    .res_merge_ok(res_merge_ok), .res_dc_cnt(res_dc_cnt)
  );

  function automatic int wid(input int i);
    return int'(SZ[3*i +: 3]);
  endfunction
  function automatic int off(input int i);
    int s = 0;
    for (int k = 0; k < i; k++) s += wid(k);
    return s;
  endfunction
  function automatic logic [3:0] lmask(input int i);
    return 4'((1 << wid(i)) - 1);
  endfunction
  function automatic logic [3:0] fld(input logic [CW-1:0] c, input int i);
    return 4'(c >> off(i)) & lmask(i);
  endfunction
  // Nibble i of nib gives field i, clipped to that field's width.
  function automatic logic [CW-1:0] mk(input logic [31:0] nib);
    logic [CW-1:0] c = '0;
    for (int i = 0; i < NV; i++) c = c | (CW'(nib[4*i +: 4] & lmask(i)) << off(i));
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Issue one command and check every result. keep_busy keeps valid high with
  // another command during the busy phase (must be ignored).
  task automatic do_cmd(input logic [2:0] op, input logic [CW-1:0] a, input logic [CW-1:0] b,
                        input string req, input bit keep_busy);
    logic [CW-1:0] er;
    longint esize;
    bit evoid, emerge;
    int edc, ndiff, lat;
    case (op)
      3'd1: er = a | b;
      3'd2: er = ~a;
      3'd3: er = a | b;
      3'd4: er = a;
      default: er = a & b;
    endcase
    esize = 1; evoid = 0; edc = 0; ndiff = 0;
    for (int i = 0; i < NV; i++) begin
      int cnt = 0;
      for (int j = 0; j < wid(i); j++) if (fld(er, i)[j]) cnt++;
      esize *= cnt;
      if (cnt == 0) evoid = 1;
      if (cnt == wid(i)) edc++;
      if (fld(a, i) != fld(b, i)) ndiff++;
    end
    emerge = (op == 3'd3) && (ndiff <= 1);

    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
    @(negedge clk);
    if (keep_busy) begin
      cmd_op = 3'd1; cmd_a = ~a; cmd_b = ~b;
    end else cmd_valid = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
      if (keep_busy && lat == 4) cmd_valid = 1'b0;
    end
    cmd_valid = 1'b0;
    check(lat == NV + 1, "R9", "done latency", lat, NV + 1);
    check(cmd_ready == 1'b1, "R9", "ready in done cycle", cmd_ready, 1);
    check(res_cube == er, req, "result cube", res_cube, er);
    check(res_size == 17'(esize), "R6", "size", res_size, esize);
    check(res_void == evoid, "R7", "void flag", res_void, evoid);
    check(res_dc_cnt == 4'(edc), "R8", "dc count", res_dc_cnt, edc);
    check(res_merge_ok == emerge, "R5", "merge flag", res_merge_ok, emerge);
    @(negedge clk);
    check(done == 1'b0, "R9", "done single pulse", done, 0);
  endtask

  task automatic t_reset();
    check(cmd_ready == 1'b1, "R11", "ready after reset", cmd_ready, 1);
    check(done == 1'b0, "R11", "done after reset", done, 0);
    check(res_cube == '0 && res_size == '0 && !res_void && !res_merge_ok && res_dc_cnt == '0,
          "R11", "results after reset", res_size, 0);
  endtask

  task automatic t_and();      // R2, R7
    do_cmd(3'd0, mk(32'h12345673), mk(32'h3a1f6f52), "R2", 0);
    do_cmd(3'd0, mk(32'h11111111), mk(32'h22222222), "R7", 0);
    do_cmd(3'd6, mk(32'h7f3f7f73), mk(32'h21122112), "R2", 0);
    do_cmd(3'd0, mk(32'h11111111), mk(32'h11111111), "R5", 0);
  endtask

  task automatic t_or();       // R3
    do_cmd(3'd1, mk(32'h11111111), mk(32'h22222222), "R3", 0);
    do_cmd(3'd1, mk(32'h14241421), mk(32'h21412142), "R3", 0);
  endtask

  task automatic t_not();      // R4, R1
    do_cmd(3'd2, mk(32'h12345671), mk(32'hffffffff), "R4", 0);
    do_cmd(3'd2, mk(32'h12345671), mk(32'h00000000), "R4", 0);
    do_cmd(3'd2, mk(32'hffffffff), mk(32'h5a5a5a5a), "R1", 0);
  endtask

  task automatic t_merge();    // R5
    do_cmd(3'd3, mk(32'h11111111), mk(32'h11121111), "R5", 0);
    do_cmd(3'd3, mk(32'h14241421), mk(32'h14241421), "R5", 0);
    do_cmd(3'd3, mk(32'h11111111), mk(32'h11121121), "R5", 0);
  endtask

  task automatic t_size();     // R6, R8, R1
    do_cmd(3'd4, mk(32'hffffffff), mk(32'h0), "R6", 0);
    check(res_size == 17'd2304, "R6", "full cube size", res_size, 2304);
    check(res_dc_cnt == 4'd8, "R8", "full cube dc", res_dc_cnt, 8);
    do_cmd(3'd4, mk(32'h11111111), mk(32'hffffffff), "R6", 0);
    check(res_size == 17'd1, "R1", "minterm size", res_size, 1);
    do_cmd(3'd4, mk(32'h3f133573), mk(32'h0), "R6", 0);
  endtask

  task automatic t_busy_ignore(); // R10
    logic [CW-1:0] a = mk(32'h12121212);
    do_cmd(3'd0, a, mk(32'h33333333), "R10", 1);
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      check(done == 1'b0, "R10", "no extra done", done, 0);
    end
    check(res_cube == (a & mk(32'h33333333)), "R10", "result kept", res_cube,
          a & mk(32'h33333333));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_and();
    t_or();
    t_not();
    t_merge();
    t_size();
    t_busy_ignore();
    finish_run();
  end
endmodule